// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block drives the command, address and control pins of a synchronous DRAM from reset until the memory is ready for normal traffic. After reset it keeps clock enable and every data mask lane high and drives the no-operation command for a settling period. The length of that period is given in nanoseconds and converted to clock cycles when the design is built. It then precharges all banks and issues a number of auto refresh commands and one mode register load. Each command is followed by the gap that the memory needs before it can accept the next one. When the last gap has elapsed the block raises a ready flag. A memory controller then takes over the pins.

The mode register word is assembled from build parameters: CAS latency, burst type, burst length and single-beat write mode. The reserved and test-mode bits are forced to zero. A parameter selects whether the mode load comes before or after the refreshes. Illegal settings stop elaboration. Examples are a CAS latency other than 2 or 3, an unsupported burst length, full-page bursts with the interleaved order, fewer than two refreshes, or a mode-load gap under two cycles.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted the outputs are `cke`=1, every `dqm` bit 1, command NOP ({cs_n,ras_n,cas_n,we_n}=0111), `addr`=0, `ba`=0 and `ready`=0.
- R2: Counting rising edges after reset release from 1, the first non-NOP command appears after edge SETTLE_CYC = ceil(SETTLE_NS*1000/CLK_PERIOD_PS). Only NOP is driven before it.
- R3: The first command is precharge-all, code 0010, with `addr` bit 10 set and all other `addr` bits and `ba` zero.
- R4: Exactly REF_COUNT auto refresh commands (code 0010 is precharge, code 0001 is refresh) are issued with `addr`=0. The first command after the precharge comes T_RP cycles after it. Each refresh is followed by a gap of T_RC cycles before the next command or ready.
- R5: One mode register load (code 0000) is issued with `ba`=0. Its `addr` is composed as follows: bits [2:0] burst length (1→000, 2→001, 4→010, 8→011, full page→111), bit 3 burst type (1 = interleaved), bits [6:4] CAS latency (2→010, 3→011), bits [8:7] 00, bit 9 single-beat write, and bits 10 and up zero.
- R6: With MODE_FIRST=0 the refreshes come before the mode load. With MODE_FIRST=1 the mode load follows the precharge directly and the refreshes follow it. The command after the mode load comes T_MRD cycles later.
- R7: `ready` rises exactly one gap after the last command: T_MRD cycles after the mode load, or T_RC cycles after the last refresh. It never rises sooner than two cycles after the mode load, and it stays high until reset.
- R8: Each command lasts exactly one cycle, and every other cycle carries NOP. `cke` and all `dqm` bits stay high throughout, and only NOP is driven once `ready` is high.
- R9: Asserting reset at any time, including after `ready`, returns the outputs to the R1 state. After release the complete sequence runs again with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| dqm | output | DQM_W | Data mask lanes |
| addr | output | ADDR_W | Multiplexed address / mode word |
| ba | output | 2 | Bank select |
| ready | output | 1 | Initialization complete, sticky |

## Verification
Two events share a single clock edge in this block. When a gap expires, the next command is issued and the shared gap counter is reloaded for the following wait. In the mode-first variant, the expiry of the final refresh gap instead raises `ready` on that edge. Two instances run side by side to provoke both cases: one loads the mode last, and the other loads it first with a settling time that is not a whole number of cycles. A negative-edge logger records the cycle index of every command and of the `ready` rise. Those indices are compared with the positions the bench computes from the parameters. An off-by-one in the reload or in the ready decision moves one of the indices.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

   typedef enum logic [3:0] {
      CMD_MRS = 4'b0000,
      CMD_REF = 4'b0001,
      CMD_PRE = 4'b0010,
      CMD_NOP = 4'b0111
   } sdram_cmd_e;

   typedef enum logic [1:0] {
      PH_SETTLE = 2'd0,
      PH_STEPS  = 2'd1,
      PH_READY  = 2'd2
   } init_phase_e;

   function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned ps);
      return int'((64'(ns) * 64'd1000 + 64'(ps) - 64'd1) / 64'(ps));
   endfunction

   function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic logic [2:0] cas_code(input int unsigned cl);
      return (cl == 3) ? 3'b011 : 3'b010;
   endfunction

endpackage

// File: rtl/sdram_mode_word.sv
module sdram_mode_word
   import sdram_init_pkg::*;
#(
   parameter int unsigned ADDR_W       = 11,
   parameter int unsigned CAS_LAT      = 3,
   parameter int unsigned BURST_TYPE   = 0,
   parameter int unsigned BURST_LEN    = 8,
   parameter int unsigned WRITE_SINGLE = 0
) (
   output logic [ADDR_W-1:0] word
);

   localparam int unsigned RSV_W = ADDR_W - 10;

   if (!(CAS_LAT == 2 || CAS_LAT == 3)) begin : g_bad_cl
      $fatal(1, "sdram_mode_word: CAS latency must be 2 or 3");
   end
   if (!(BURST_LEN == 1 || BURST_LEN == 2 || BURST_LEN == 4 ||
         BURST_LEN == 8 || BURST_LEN == 256)) begin : g_bad_bl
      $fatal(1, "sdram_mode_word: burst length must be 1, 2, 4, 8 or 256");
   end
   if (BURST_LEN == 256 && BURST_TYPE != 0) begin : g_bad_full
      $fatal(1, "sdram_mode_word: full-page bursts need the sequential order");
   end
   if (BURST_TYPE > 1 || WRITE_SINGLE > 1) begin : g_bad_flag
      $fatal(1, "sdram_mode_word: burst type and write mode are single bits");
   end
   if (ADDR_W < 11) begin : g_bad_aw
      $fatal(1, "sdram_mode_word: address bus needs at least 11 bits");
   end

   logic [2:0] len_code;
   logic [2:0] lat_code;
   logic       type_bit;
   logic       wmode_bit;

   if (BURST_LEN == 256) begin : g_full_page
      assign len_code = 3'b111;
   end else begin : g_short_burst
      assign len_code = 3'($clog2(BURST_LEN));
   end

   assign lat_code  = cas_code(CAS_LAT);
   assign type_bit  = (BURST_TYPE == 1);
   assign wmode_bit = (WRITE_SINGLE == 1);

   assign word = {{RSV_W{1'b0}}, wmode_bit, 2'b00, lat_code, type_bit, len_code};

endmodule

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
   parameter int unsigned       CNT_W   = 16,
   parameter logic [CNT_W-1:0]  RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= RST_VAL;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
   import sdram_init_pkg::*;
#(
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned REF_COUNT  = 2,
   parameter int unsigned MODE_FIRST = 0,
   parameter int unsigned T_RP       = 2,
   parameter int unsigned T_RC       = 7,
   parameter int unsigned T_MRD      = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             expired,
   output logic             issue,
   output sdram_cmd_e       issue_cmd,
   output logic [CNT_W-1:0] gap_val,
   output logic             go_ready
);

   localparam int unsigned RC_W = $clog2(REF_COUNT + 1);

   init_phase_e     phase_q, phase_d;
   logic [RC_W-1:0] ref_cnt_q;
   logic            mrs_done_q;
   logic            refs_left;
   sdram_cmd_e      pick;

   assign refs_left = (ref_cnt_q < RC_W'(REF_COUNT));

   if (MODE_FIRST != 0) begin : g_mode_first
      always_comb begin
         if (!mrs_done_q)    pick = CMD_MRS;
         else if (refs_left) pick = CMD_REF;
         else                pick = CMD_NOP;
      end
   end else begin : g_refresh_first
      always_comb begin
         if (refs_left)        pick = CMD_REF;
         else if (!mrs_done_q) pick = CMD_MRS;
         else                  pick = CMD_NOP;
      end
   end

   always_comb begin
      issue     = 1'b0;
      issue_cmd = CMD_NOP;
      go_ready  = 1'b0;
      phase_d   = phase_q;
      if (expired) begin
         unique case (phase_q)
            PH_SETTLE: begin
               issue     = 1'b1;
               issue_cmd = CMD_PRE;
               phase_d   = PH_STEPS;
            end
            PH_STEPS: begin
               if (pick == CMD_NOP) begin
                  go_ready = 1'b1;
                  phase_d  = PH_READY;
               end else begin
                  issue     = 1'b1;
                  issue_cmd = pick;
               end
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      unique case (issue_cmd)
         CMD_PRE: gap_val = CNT_W'(T_RP - 1);
         CMD_REF: gap_val = CNT_W'(T_RC - 1);
         CMD_MRS: gap_val = CNT_W'(T_MRD - 1);
         default: gap_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= PH_SETTLE;
         ref_cnt_q  <= '0;
         mrs_done_q <= 1'b0;
      end else begin
         phase_q <= phase_d;
         if (issue && issue_cmd == CMD_REF) ref_cnt_q  <= ref_cnt_q + RC_W'(1);
         if (issue && issue_cmd == CMD_MRS) mrs_done_q <= 1'b1;
      end
   end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
   import sdram_init_pkg::*;
#(
   parameter int unsigned ADDR_W        = 11,
   parameter int unsigned DQM_W         = 4,
   parameter int unsigned CLK_PERIOD_PS = 10000,
   parameter int unsigned SETTLE_NS     = 200000,
   parameter int unsigned T_RP          = 2,
   parameter int unsigned T_RC          = 7,
   parameter int unsigned T_MRD         = 2,
   parameter int unsigned REF_COUNT     = 2,
   parameter int unsigned MODE_FIRST    = 0,
   parameter int unsigned CAS_LAT       = 3,
   parameter int unsigned BURST_TYPE    = 0,
   parameter int unsigned BURST_LEN     = 8,
   parameter int unsigned WRITE_SINGLE  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              cke,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [DQM_W-1:0]  dqm,
   output logic [ADDR_W-1:0] addr,
   output logic [1:0]        ba,
   output logic              ready
);

   localparam int unsigned SETTLE_CYC = ns_to_cycles(SETTLE_NS, CLK_PERIOD_PS);
   localparam int unsigned MAX_GAP    = max_of(max_of(SETTLE_CYC, T_RC), max_of(T_RP, T_MRD));
   localparam int unsigned CNT_W      = $clog2(MAX_GAP + 1);
   localparam logic [ADDR_W-1:0] PRE_ALL_WORD = ADDR_W'(1) << 10;

   if (CLK_PERIOD_PS == 0 || SETTLE_CYC < 1) begin : g_bad_clk
      $fatal(1, "sdram_init_seq: clock period and settling time must be non-zero");
   end
   if (REF_COUNT < 2) begin : g_bad_refs
      $fatal(1, "sdram_init_seq: at least two refreshes are required");
   end
   if (T_MRD < 2 || T_RP < 1 || T_RC < 1) begin : g_bad_gaps
      $fatal(1, "sdram_init_seq: gap lengths out of range");
   end

   logic [ADDR_W-1:0] mode_word;
   logic              expired;
   logic              issue;
   sdram_cmd_e        issue_cmd;
   logic [CNT_W-1:0]  gap_val;
   logic              go_ready;

   sdram_cmd_e        cmd_q;
   logic [ADDR_W-1:0] addr_q;
   logic              ready_q;

   sdram_mode_word #(
      .ADDR_W       (ADDR_W),
      .CAS_LAT      (CAS_LAT),
      .BURST_TYPE   (BURST_TYPE),
      .BURST_LEN    (BURST_LEN),
      .WRITE_SINGLE (WRITE_SINGLE)
   ) u_mode (
      .word (mode_word)
   );

   sdram_gap_timer #(
      .CNT_W   (CNT_W),
      .RST_VAL (CNT_W'(SETTLE_CYC - 1))
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (issue),
      .load_val (gap_val),
      .expired  (expired)
   );

   sdram_init_ctrl #(
      .CNT_W      (CNT_W),
      .REF_COUNT  (REF_COUNT),
      .MODE_FIRST (MODE_FIRST),
      .T_RP       (T_RP),
      .T_RC       (T_RC),
      .T_MRD      (T_MRD)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .expired   (expired),
      .issue     (issue),
      .issue_cmd (issue_cmd),
      .gap_val   (gap_val),
      .go_ready  (go_ready)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q   <= CMD_NOP;
         addr_q  <= '0;
         ready_q <= 1'b0;
      end else begin
         ready_q <= ready_q | go_ready;
         if (issue) begin
            cmd_q <= issue_cmd;
            unique case (issue_cmd)
               CMD_PRE: addr_q <= PRE_ALL_WORD;
               CMD_MRS: addr_q <= mode_word;
               default: addr_q <= '0;
            endcase
         end else begin
            cmd_q  <= CMD_NOP;
            addr_q <= '0;
         end
      end
   end

   assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
   assign addr  = addr_q;
   assign ba    = 2'b00;
   assign cke   = 1'b1;
   assign dqm   = {DQM_W{1'b1}};
   assign ready = ready_q;

endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
   parameter int unsigned ADDR_W = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              ras_n,
   input logic              cas_n,
   input logic              we_n,
   input logic [ADDR_W-1:0] addr,
   input logic              ready
);

   logic [3:0] cmd;
   logic [2:0] mrs_age_q;

   assign cmd = {cs_n, ras_n, cas_n, we_n};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 mrs_age_q <= 3'd0;
      else if (cmd == 4'b0000)                    mrs_age_q <= 3'd1;
      else if (mrs_age_q != 3'd0 && mrs_age_q != 3'd7) mrs_age_q <= mrs_age_q + 3'd1;
   end

   a_r3_pre_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 4'b0010) |-> addr[10]);

   a_r5_mode_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 4'b0000) |-> (addr[ADDR_W-1:10] == '0 && addr[8:7] == 2'b00 &&
                            (addr[6:4] == 3'b010 || addr[6:4] == 3'b011)));

   a_r8_single_cycle_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd != 4'b0111) |=> (cmd == 4'b0111));

   a_r7_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> ready);

   a_r7_ready_after_mode: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> (mrs_age_q >= 3'd2));

   a_r8_quiet_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (cmd == 4'b0111));

endmodule

bind sdram_init_seq sdram_init_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .cs_n  (cs_n),
   .ras_n (ras_n),
   .cas_n (cas_n),
   .we_n  (we_n),
   .addr  (addr),
   .ready (ready)
);

// File: tb/sim_sdram_init_seq.sv
module sim_cmd_log (
   input logic        clk,
   input logic        rst_n,
   input int          cyc,
   input logic        cke,
   input logic        cs_n,
   input logic        ras_n,
   input logic        cas_n,
   input logic        we_n,
   input logic [3:0]  dqm,
   input logic [10:0] addr,
   input logic [1:0]  ba,
   input logic        ready
);
   int          ev_cyc  [0:15];
   logic [3:0]  ev_cmd  [0:15];
   logic [10:0] ev_addr [0:15];
   logic [1:0]  ev_ba   [0:15];
   int          n_ev = 0;
   int          rdy_cyc = -1;
   int          v_pins = 0;
   int          v_bus = 0;
   int          v_drop = 0;
   logic [3:0]  prev_cmd = 4'b0111;
   logic        prev_rdy = 1'b0;

   always @(negedge clk) begin
      logic [3:0] c;
      c = {cs_n, ras_n, cas_n, we_n};
      if (!rst_n) begin
         n_ev = 0; rdy_cyc = -1; v_pins = 0; v_bus = 0; v_drop = 0;
         prev_cmd = 4'b0111; prev_rdy = 1'b0;
      end else begin
         if (!cke || dqm != 4'hF) v_pins++;
         if (c != 4'b0111 && (prev_cmd != 4'b0111 || ready)) v_bus++;
         if (prev_rdy && !ready) v_drop++;
         if (c != 4'b0111 && n_ev < 16) begin
            ev_cyc[n_ev] = cyc; ev_cmd[n_ev] = c;
            ev_addr[n_ev] = addr; ev_ba[n_ev] = ba;
            n_ev++;
         end
         if (ready && !prev_rdy) rdy_cyc = cyc;
         prev_cmd = c; prev_rdy = ready;
      end
   end
endmodule

module sim_sdram_init_seq;
   localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

   // instance u0: 10 ns clock, 200 us settle, refresh first
   localparam int U0_SET = (200000 * 1000 + 10000 - 1) / 10000;
   localparam int U0_RP = 2, U0_RC = 7, U0_MRD = 2;
   // CL3 -> 011, sequential, burst 8 -> 011, multi-beat writes
   localparam logic [10:0] U0_MODE = 11'h033;

   // instance u1: 7.5 ns nominal period, 1 us settle (ceiling), mode first, three refreshes
   localparam int U1_SET = (1000 * 1000 + 7500 - 1) / 7500;
   localparam int U1_RP = 3, U1_RC = 5, U1_MRD = 2;
   // CL2 -> 010, interleaved, burst 4 -> 010, single-beat writes
   localparam logic [10:0] U1_MODE = 11'h22A;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   int   cyc;
   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;

   always #5 clk = ~clk;

   always @(posedge clk or negedge rst_n)
      if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

   logic        cke0, cs0, ras0, cas0, we0, rdy0;
   logic [3:0]  dqm0;
   logic [10:0] addr0;
   logic [1:0]  ba0;
   logic        cke1, cs1, ras1, cas1, we1, rdy1;
   logic [3:0]  dqm1;
   logic [10:0] addr1;
   logic [1:0]  ba1;

   sdram_init_seq #(
      .CLK_PERIOD_PS(10000), .SETTLE_NS(200000), .T_RP(U0_RP), .T_RC(U0_RC),
      .T_MRD(U0_MRD), .REF_COUNT(2), .MODE_FIRST(0), .CAS_LAT(3),
      .BURST_TYPE(0), .BURST_LEN(8), .WRITE_SINGLE(0)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .cke(cke0), .cs_n(cs0), .ras_n(ras0), .cas_n(cas0),
      .we_n(we0), .dqm(dqm0), .addr(addr0), .ba(ba0), .ready(rdy0)
   );

   sdram_init_seq #(
      .CLK_PERIOD_PS(7500), .SETTLE_NS(1000), .T_RP(U1_RP), .T_RC(U1_RC),
      .T_MRD(U1_MRD), .REF_COUNT(3), .MODE_FIRST(1), .CAS_LAT(2),
      .BURST_TYPE(1), .BURST_LEN(4), .WRITE_SINGLE(1)
   ) u1 (
      .clk(clk), .rst_n(rst_n), .cke(cke1), .cs_n(cs1), .ras_n(ras1), .cas_n(cas1),
      .we_n(we1), .dqm(dqm1), .addr(addr1), .ba(ba1), .ready(rdy1)
   );

   sim_cmd_log u_log0 (.clk(clk), .rst_n(rst_n), .cyc(cyc), .cke(cke0), .cs_n(cs0),
      .ras_n(ras0), .cas_n(cas0), .we_n(we0), .dqm(dqm0), .addr(addr0), .ba(ba0), .ready(rdy0));
   sim_cmd_log u_log1 (.clk(clk), .rst_n(rst_n), .cyc(cyc), .cke(cke1), .cs_n(cs1),
      .ras_n(ras1), .cas_n(cas1), .we_n(we1), .dqm(dqm1), .addr(addr1), .ba(ba1), .ready(rdy1));

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      while (cyc < n) @(negedge clk);
   endtask

   // R1 / R9: idle pin state while reset is held
   task automatic t_reset_state(input string tag);
      chk({tag, " u0 pins"}, {cke0, dqm0, cs0, ras0, cas0, we0, rdy0}, {1'b1, 4'hF, NOP, 1'b0});
      chk({tag, " u0 addr/ba"}, {addr0, ba0}, 13'h0);
      chk({tag, " u1 pins"}, {cke1, dqm1, cs1, ras1, cas1, we1, rdy1}, {1'b1, 4'hF, NOP, 1'b0});
      chk({tag, " u1 addr/ba"}, {addr1, ba1}, 13'h0);
   endtask

   // R2..R8 on u0: refreshes then mode load
   task automatic t_seq_refresh_first();
      int p;
      p = U0_SET;
      wait_cyc(p + U0_RP + 2 * U0_RC + U0_MRD + 4);
      chk("R2 u0 first command cycle", u_log0.ev_cyc[0], p);
      chk("R3 u0 precharge code", u_log0.ev_cmd[0], PRE);
      chk("R3 u0 precharge addr", {u_log0.ev_addr[0], u_log0.ev_ba[0]}, {11'h400, 2'b00});
      chk("R4 u0 refresh 1", {u_log0.ev_cmd[1], 32'(u_log0.ev_cyc[1])}, {REF, 32'(p + U0_RP)});
      chk("R4 u0 refresh 2", {u_log0.ev_cmd[2], 32'(u_log0.ev_cyc[2])}, {REF, 32'(p + U0_RP + U0_RC)});
      chk("R4 u0 refresh addr", u_log0.ev_addr[1], 0);
      chk("R6 u0 mode after refreshes", {u_log0.ev_cmd[3], 32'(u_log0.ev_cyc[3])},
          {MRS, 32'(p + U0_RP + 2 * U0_RC)});
      chk("R5 u0 mode word", {u_log0.ev_addr[3], u_log0.ev_ba[3]}, {U0_MODE, 2'b00});
      chk("R4 u0 command count", u_log0.n_ev, 4);
      chk("R7 u0 ready cycle", u_log0.rdy_cyc, p + U0_RP + 2 * U0_RC + U0_MRD);
   endtask

   // R2 ceiling, R4..R7 on u1: mode load first, three refreshes
   task automatic t_seq_mode_first();
      int p;
      p = U1_SET;
      wait_cyc(p + U1_RP + U1_MRD + 3 * U1_RC + 4);
      chk("R2 u1 settle ceiling", u_log1.ev_cyc[0], 134);
      chk("R3 u1 precharge", {u_log1.ev_cmd[0], u_log1.ev_addr[0]}, {PRE, 11'h400});
      chk("R6 u1 mode right after precharge", {u_log1.ev_cmd[1], 32'(u_log1.ev_cyc[1])},
          {MRS, 32'(p + U1_RP)});
      chk("R5 u1 mode word", {u_log1.ev_addr[1], u_log1.ev_ba[1]}, {U1_MODE, 2'b00});
      for (int i = 0; i < 3; i++)
         chk("R4 u1 refresh", {u_log1.ev_cmd[2+i], 32'(u_log1.ev_cyc[2+i])},
             {REF, 32'(p + U1_RP + U1_MRD + i * U1_RC)});
      chk("R4 u1 command count", u_log1.n_ev, 5);
      chk("R7 u1 ready after last refresh", u_log1.rdy_cyc, p + U1_RP + U1_MRD + 3 * U1_RC);
   endtask

   // R7 / R8: ready holds, bus stays quiet, control pins stay high
   task automatic t_hold_after_ready();
      repeat (40) @(negedge clk);
      chk("R7 ready held", {rdy0, rdy1}, 2'b11);
      chk("R7 ready never dropped", u_log0.v_drop + u_log1.v_drop, 0);
      chk("R8 cke/dqm high", u_log0.v_pins + u_log1.v_pins, 0);
      chk("R8 single-cycle commands and quiet bus", u_log0.v_bus + u_log1.v_bus, 0);
      chk("R8 u0 bus NOP after ready", {cs0, ras0, cas0, we0, addr0}, {NOP, 11'h0});
   endtask

   // R9: reset after ready returns to idle and the sequence repeats
   task automatic t_restart();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      t_reset_state("R9 reset after ready");
      rst_n = 1'b1;
      wait_cyc(U1_SET - 1);
      chk("R9 u1 quiet before settle end", u_log1.n_ev, 0);
      wait_cyc(U1_SET + U1_RP + U1_MRD + 3 * U1_RC + 2);
      chk("R9 u1 restart precharge cycle", u_log1.ev_cyc[0], U1_SET);
      chk("R9 u1 restart ready cycle", u_log1.rdy_cyc, U1_SET + U1_RP + U1_MRD + 3 * U1_RC);
      chk("R9 u0 still settling", {u_log0.n_ev, rdy0}, 0);
   endtask

   initial begin
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      t_reset_state("R1 reset");
      rst_n = 1'b1;
      t_seq_mode_first();
      t_seq_refresh_first();
      t_hold_after_ready();
      t_restart();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R8 watchdog actual running expected finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule